// File: doc/BRIEF.md
# LIN Master Frame Command Sequencer

This block runs LIN frames as the bus master at byte level. Frame settings come from one of two places. With the mode input low, they come from static setting inputs, and a `start` pulse launches the frame. With the mode input high, they are taken from the leading bytes of a byte-wide write stream, in the way a DMA engine would deliver them. Each frame is sent on a byte-level bus port as a break symbol, the sync byte 0x55, the protected identifier and then the response. Baud-rate timing and the transceiver sit behind that port.

In a publish frame, the master supplies the response data from the write stream and appends the checksum. In a subscribe frame, the responding node's bytes are received, handed to a consumer on a read port and checked against their checksum. In an ignore frame, the response is received and checked but never handed on.

The write port and the bus transmit port are valid/ready interfaces. A byte moves on any clock where both valid and ready are high, and the sender must hold valid and data until then. The bus receive side cannot be stalled. Received bytes go into a one-byte read holding register, which the consumer must drain with `rd_ready` before the next response byte arrives. A byte that arrives while the register is still full replaces the old one.

Top module: `lin_frame_seq`

## Requirements
- R1: After reset, `bus_valid`, `rd_valid`, `done` and `chk_err` are low, and with `cfg_inband` low `wr_ready` is low.
- R2: With `cfg_inband` low, a `start` pulse launches a frame built from `st_act`, `st_pardis`, `st_chkdis`, `st_chktyp`, `st_dlc` and `st_id`. While such a frame is idle, `wr_ready` stays low, so bytes offered on the write port are not consumed and start no frame.
- R3: With `cfg_inband` high, the first accepted write byte is the setting byte. Its bits are: [1:0] action (0 publish, 1 subscribe, 2 ignore, 3 treated as ignore), [2] parity off, [3] checksum off, [4] enhanced checksum. Bits [7:5] have no effect. The second accepted byte holds N-1 in bits [2:0]. `start` has no effect in this mode.
- R4: With `cfg_inband` high and a publish action, the third accepted write byte is the identifier byte. Subscribe and ignore frames take the identifier from `st_id`.
- R5: The bus sequence is a break symbol (`bus_brk`=1, data 0), then 0x55, then the protected identifier, then the N data bytes, then the checksum. The break is held valid until it is accepted.
- R6: With parity on, the protected identifier is {P1,P0,ID[5:0]}, where P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). With parity off, the identifier byte is sent unchanged.
- R7: The checksum is the inverted 8-bit sum with end-around carry. The classic type covers only the data bytes, and the enhanced type also adds the protected identifier. With checksum off, no checksum byte is sent or expected.
- R8: In a publish frame, exactly N data bytes pass from the write port to the bus in order, with `wr_ready` following `bus_ready` during the data phase.
- R9: In a subscribe frame, each response byte seen with `bus_rx_valid` appears on `rd_data`, with `rd_valid` set, on the next cycle. It stays there unchanged until `rd_ready` takes it.
- R10: In an ignore frame, response bytes never raise `rd_valid`.
- R11: `done` pulses for one cycle in the cycle after the checksum byte is sent or received, or after the last data byte when the checksum is off. `chk_err` is high with `done` only when a received checksum does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_inband | input | 1 | 1: settings come from the write stream; 0: from static inputs |
| start | input | 1 | Launches a frame in static mode |
| st_act | input | 2 | Static action (0 publish, 1 subscribe, 2 ignore) |
| st_pardis | input | 1 | Static parity off |
| st_chkdis | input | 1 | Static checksum off |
| st_chktyp | input | 1 | Static enhanced checksum select |
| st_dlc | input | 3 | Static data count minus one |
| st_id | input | 8 | Static identifier byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream ready (transmit-ready) |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read holding register full (receive-ready) |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Received response byte |
| bus_valid | output | 1 | Bus symbol valid |
| bus_ready | input | 1 | Bus accepts the symbol |
| bus_brk | output | 1 | Symbol is a break |
| bus_data | output | 8 | Bus byte |
| bus_rx_valid | input | 1 | Response byte received from the bus |
| bus_rx_data | input | 8 | Received response byte |
| done | output | 1 | Frame complete pulse |
| chk_err | output | 1 | Received checksum mismatch, valid with done |

## Verification
Some properties are checked on every cycle:
- A break stays presented under back-pressure.
- `done` is a single-cycle pulse with no bus or write traffic beside it.
- `chk_err` appears only with `done`.
- A waiting read byte stays stable until it is taken.

Other behaviour can only be shown by the bench's scenarios, against a model that predicts each bus symbol and read byte:
- the parsing of the setting bytes, including the ignored upper bits;
- the choice of identifier source;
- parity and both checksum types, and the byte order of whole frames;
- the silence of ignore frames;
- the deafness of each mode to the other mode's trigger.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;

  typedef enum logic [1:0] {
    ACT_PUB = 2'd0,
    ACT_SUB = 2'd1,
    ACT_IGN = 2'd2,
    ACT_RSV = 2'd3
  } lin_act_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CFG1, S_ID, S_BRK, S_SYNC, S_PID,
    S_TXD, S_TXC, S_RXD, S_RXC, S_DONE
  } lin_st_e;

  typedef struct packed {
    lin_act_e act;
    logic     pardis;
    logic     chkdis;
    logic     chktyp;
  } lin_cfg_t;

  function automatic lin_cfg_t cfg_from_byte(input logic [7:0] b);
    lin_cfg_t c;
    c.act    = lin_act_e'(b[1:0]);
    c.pardis = b[2];
    c.chkdis = b[3];
    c.chktyp = b[4];
    return c;
  endfunction

  function automatic logic [7:0] lin_pid(input logic [7:0] idb, input logic pardis);
    logic p0, p1;
    p0 = idb[0] ^ idb[1] ^ idb[2] ^ idb[4];
    p1 = ~(idb[1] ^ idb[3] ^ idb[4] ^ idb[5]);
    return pardis ? idb : {p1, p0, idb[5:0]};
  endfunction

  function automatic logic [7:0] csum_step(input logic [7:0] s, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, s} + {1'b0, b};
    return t[7:0] + {7'd0, t[8]};
  endfunction

endpackage

// File: rtl/lin_csum_acc.sv
module lin_csum_acc
  import lin_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       add,
  input  logic [7:0] add_byte,
  output logic [7:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sum <= '0;
    else if (load) sum <= load_val;
    else if (add)  sum <= csum_step(sum, add_byte);
  end
endmodule

// File: rtl/lin_rx_hold.sv
module lin_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (push) begin
      rd_valid <= 1'b1;
      rd_data  <= push_data;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl
  import lin_seq_pkg::*;
#(
  parameter int         LEN_W    = 3,
  parameter logic [7:0] SYNC_VAL = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_inband,
  input  logic             start,
  input  lin_cfg_t         st_cfg,
  input  logic [LEN_W-1:0] st_dlc,
  input  logic [7:0]       st_id,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_brk,
  output logic [7:0]       bus_data,
  input  logic             bus_rx_valid,
  input  logic [7:0]       bus_rx_data,
  input  logic [7:0]       csum,
  output logic             sum_load,
  output logic [7:0]       sum_init,
  output logic             sum_add,
  output logic [7:0]       sum_byte,
  output logic             rx_push,
  output logic             done,
  output logic             chk_err
);
  lin_st_e          st;
  lin_cfg_t         cfg;
  logic [LEN_W-1:0] dlc, cnt;
  logic [7:0]       idb, pid;
  logic             err_q, last, is_pub;

  assign pid    = lin_pid(idb, cfg.pardis);
  assign last   = (cnt == dlc);
  assign is_pub = (cfg.act == ACT_PUB);

  always_comb begin
    wr_ready  = 1'b0;
    bus_valid = 1'b0;
    bus_brk   = 1'b0;
    bus_data  = 8'h00;
    done      = 1'b0;
    chk_err   = 1'b0;
    case (st)
      S_IDLE:        wr_ready = cfg_inband;
      S_CFG1, S_ID:  wr_ready = 1'b1;
      S_BRK:  begin bus_valid = 1'b1; bus_brk = 1'b1; end
      S_SYNC: begin bus_valid = 1'b1; bus_data = SYNC_VAL; end
      S_PID:  begin bus_valid = 1'b1; bus_data = pid; end
      S_TXD:  begin bus_valid = wr_valid; bus_data = wr_data; wr_ready = bus_ready; end
      S_TXC:  begin bus_valid = 1'b1; bus_data = ~csum; end
      S_DONE: begin done = 1'b1; chk_err = err_q; end
      default: ;
    endcase
  end

  assign sum_load = (st == S_PID) && bus_ready;
  assign sum_init = cfg.chktyp ? pid : 8'h00;
  assign sum_add  = ((st == S_TXD) && wr_valid && bus_ready) ||
                    ((st == S_RXD) && bus_rx_valid);
  assign sum_byte = (st == S_TXD) ? wr_data : bus_rx_data;
  assign rx_push  = (st == S_RXD) && bus_rx_valid && (cfg.act == ACT_SUB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cfg   <= '0;
      dlc   <= '0;
      cnt   <= '0;
      idb   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          err_q <= 1'b0;
          cnt   <= '0;
          if (cfg_inband && wr_valid) begin
            cfg <= cfg_from_byte(wr_data);
            st  <= S_CFG1;
          end else if (!cfg_inband && start) begin
            cfg <= st_cfg;
            dlc <= st_dlc;
            idb <= st_id;
            st  <= S_BRK;
          end
        end
        S_CFG1: if (wr_valid) begin
          dlc <= wr_data[LEN_W-1:0];
          idb <= st_id;
          st  <= is_pub ? S_ID : S_BRK;
        end
        S_ID: if (wr_valid) begin
          idb <= wr_data;
          st  <= S_BRK;
        end
        S_BRK:  if (bus_ready) st <= S_SYNC;
        S_SYNC: if (bus_ready) st <= S_PID;
        S_PID:  if (bus_ready) st <= is_pub ? S_TXD : S_RXD;
        S_TXD: if (wr_valid && bus_ready) begin
          cnt <= cnt + 1'b1;
          if (last) st <= cfg.chkdis ? S_DONE : S_TXC;
        end
        S_TXC: if (bus_ready) st <= S_DONE;
        S_RXD: if (bus_rx_valid) begin
          cnt <= cnt + 1'b1;
          if (last) st <= cfg.chkdis ? S_DONE : S_RXC;
        end
        S_RXC: if (bus_rx_valid) begin
          err_q <= (bus_rx_data != ~csum);
          st    <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lin_frame_seq.sv
module lin_frame_seq
  import lin_seq_pkg::*;
#(
  parameter int         MAX_BYTES = 8,
  parameter logic [7:0] SYNC_VAL  = 8'h55,
  localparam int        LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_inband,
  input  logic             start,
  input  logic [1:0]       st_act,
  input  logic             st_pardis,
  input  logic             st_chkdis,
  input  logic             st_chktyp,
  input  logic [LEN_W-1:0] st_dlc,
  input  logic [7:0]       st_id,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_brk,
  output logic [7:0]       bus_data,
  input  logic             bus_rx_valid,
  input  logic [7:0]       bus_rx_data,
  output logic             done,
  output logic             chk_err
);
  lin_cfg_t   st_cfg;
  logic [7:0] csum, sum_init, sum_byte;
  logic       sum_load, sum_add, rx_push;

  assign st_cfg.act    = lin_act_e'(st_act);
  assign st_cfg.pardis = st_pardis;
  assign st_cfg.chkdis = st_chkdis;
  assign st_cfg.chktyp = st_chktyp;

  lin_frame_ctrl #(.LEN_W(LEN_W), .SYNC_VAL(SYNC_VAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_inband(cfg_inband), .start(start),
    .st_cfg(st_cfg), .st_dlc(st_dlc), .st_id(st_id),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_brk(bus_brk), .bus_data(bus_data),
    .bus_rx_valid(bus_rx_valid), .bus_rx_data(bus_rx_data),
    .csum(csum), .sum_load(sum_load), .sum_init(sum_init),
    .sum_add(sum_add), .sum_byte(sum_byte), .rx_push(rx_push),
    .done(done), .chk_err(chk_err)
  );

  lin_csum_acc u_csum (
    .clk(clk), .rst_n(rst_n), .load(sum_load), .load_val(sum_init),
    .add(sum_add), .add_byte(sum_byte), .sum(csum)
  );

  lin_rx_hold #(.W(8)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(bus_rx_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );
endmodule

// File: rtl/lin_frame_seq_chk.sv
module lin_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic       bus_brk,
  input logic       bus_rx_valid,
  input logic       done,
  input logic       chk_err
);
  // R5
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_brk && !bus_ready |=> bus_valid && bus_brk);

  // R5
  brk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_brk |-> bus_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> done);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid && !wr_ready);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !bus_rx_valid |=> rd_valid && $stable(rd_data));
endmodule

bind lin_frame_seq lin_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_brk(bus_brk), .bus_rx_valid(bus_rx_valid),
  .done(done), .chk_err(chk_err)
);

// File: tb/lin_frame_seq_tb.sv
module lin_frame_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_inband = 1'b0, start = 1'b0;
  logic [1:0] st_act = '0;
  logic       st_pardis = 1'b0, st_chkdis = 1'b0, st_chktyp = 1'b0;
  logic [2:0] st_dlc = '0;
  logic [7:0] st_id = '0;
  logic       wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       bus_valid, bus_ready = 1'b0, bus_brk;
  logic [7:0] bus_data;
  logic       bus_rx_valid = 1'b0;
  logic [7:0] bus_rx_data = '0;
  logic       done, chk_err;

  int checks = 0, errors = 0;
  logic [8:0] exp_bus[$];
  logic [7:0] exp_rd[$];
  bit got_done = 0, got_err = 0;

  lin_frame_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic fail_msg(input string req, input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) fail_msg(req, act, exp);
  endtask

  // back-pressure patterns on the bus and the consumer
  initial begin
    int rc = 0;
    forever begin
      @(posedge clk); #1;
      rc++;
      bus_ready = (rc % 4) != 1;
      rd_ready  = (rc % 3) != 0;
    end
  end

  // reference comparison on every clock
  always @(negedge clk) if (rst_n) begin
    if (bus_valid && bus_ready) begin
      checks++;
      if (exp_bus.size() == 0) fail_msg("R5 unexpected bus symbol", {bus_brk, bus_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_bus.pop_front();
        if ({bus_brk, bus_data} !== e) fail_msg("R5/R6/R7/R8 bus symbol", {bus_brk, bus_data}, e);
      end
    end
    if (rd_valid && exp_rd.size() == 0) fail_msg("R10 unexpected read byte", rd_data, 0);
    else if (rd_valid && rd_ready) begin
      logic [7:0] e;
      checks++;
      e = exp_rd.pop_front();
      if (rd_data !== e) fail_msg("R9 read byte", rd_data, e);
    end
    if (done) begin
      got_done = 1;
      got_err  = chk_err;
      if (exp_bus.size() != 0) fail_msg("R11 done before frame end", exp_bus.size(), 0);
    end
  end

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic drive_rx(input logic [7:0] b);
    @(posedge clk); #1;
    bus_rx_valid = 1'b1;
    bus_rx_data  = b;
    @(posedge clk); #1;
    bus_rx_valid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic run_frame(input bit inband, input logic [1:0] act, input bit pd,
                           input bit cd, input bit ct, input logic [2:0] dlc,
                           input logic [7:0] id, input logic [2:0] hi,
                           input bit bad, input logic [7:0] seed, input string tag);
    logic [7:0] d[8];
    logic [7:0] pid, ck;
    int s, n;
    bit rx;
    n  = int'(dlc) + 1;
    rx = (act != 2'd0);
    for (int i = 0; i < 8; i++) d[i] = seed + 8'(i * 37);
    if (pd) pid = id;
    else pid = {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4], id[5:0]};
    s = ct ? int'(pid) : 0;
    for (int i = 0; i < n; i++) begin
      s = s + int'(d[i]);
      while (s > 255) s = (s & 255) + (s >> 8);
    end
    ck = ~s[7:0];
    exp_bus.push_back(9'h100);
    exp_bus.push_back(9'h055);
    exp_bus.push_back({1'b0, pid});
    if (!rx) begin
      for (int i = 0; i < n; i++) exp_bus.push_back({1'b0, d[i]});
      if (!cd) exp_bus.push_back({1'b0, ck});
    end
    if (act == 2'd1) for (int i = 0; i < n; i++) exp_rd.push_back(d[i]);
    got_done = 0;
    cfg_inband = inband;
    // R4: in-band publish must not use the static identifier
    st_id = (inband && act == 2'd0) ? ~id : id;
    if (!inband) begin
      st_act = act; st_pardis = pd; st_chkdis = cd; st_chktyp = ct; st_dlc = dlc;
      @(posedge clk); #1; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    fork
      begin
        if (inband) begin
          put({hi, ct, cd, pd, act});
          put({hi, 2'b00, dlc});
          if (act == 2'd0) put(id);
        end
        if (!rx) for (int i = 0; i < n; i++) put(d[i]);
      end
      begin
        if (rx) begin
          while (exp_bus.size() != 0) @(negedge clk);
          for (int i = 0; i < n; i++) drive_rx(d[i]);
          if (!cd) drive_rx(bad ? (ck ^ 8'h01) : ck);
        end
      end
    join
    for (int k = 0; k < 400 && !got_done; k++) @(negedge clk);
    chk({"R11 done ", tag}, got_done, 1);
    chk({"R11 chk_err ", tag}, got_err, rx && !cd && bad);
    repeat (6) @(negedge clk);
    chk({"R8/R5 bus queue drained ", tag}, exp_bus.size(), 0);
    chk({"R9/R10 read queue drained ", tag}, exp_rd.size(), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    chk("R1 bus_valid in reset", bus_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus_valid", bus_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 chk_err", chk_err, 0);
    chk("R1 wr_ready static", wr_ready, 0);
    @(posedge clk); #1;

    // R2: static idle does not consume the stream
    wr_valid = 1'b1; wr_data = 8'h00;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R2 static idle wr_ready", wr_ready, 0);
      chk("R2 static idle bus_valid", bus_valid, 0);
    end
    @(posedge clk); #1; wr_valid = 1'b0;

    // R3: start has no effect in in-band mode
    cfg_inband = 1'b1;
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R3 start ignored in-band", bus_valid, 0);
    end
    @(posedge clk); #1;

    // inband, act, pd, cd, ct, dlc, id, hi, bad, seed
    run_frame(1, 2'd0, 0, 0, 0, 3'd3, 8'h12, 3'd0, 0, 8'h11, "R3 R4 R6 R7 R8 publish classic");
    run_frame(1, 2'd0, 0, 0, 1, 3'd7, 8'h3C, 3'd7, 0, 8'hF0, "R3 R7 publish enhanced 8 bytes, upper bits set");
    run_frame(1, 2'd0, 1, 1, 0, 3'd0, 8'hA5, 3'd0, 0, 8'h42, "R6 R7 parity off, checksum off, 1 byte");
    run_frame(1, 2'd1, 0, 0, 0, 3'd2, 8'h21, 3'd0, 0, 8'h80, "R4 R9 subscribe classic");
    run_frame(1, 2'd1, 0, 0, 1, 3'd5, 8'h07, 3'd5, 1, 8'hFE, "R9 R11 subscribe enhanced bad checksum");
    run_frame(1, 2'd2, 0, 0, 0, 3'd4, 8'h30, 3'd0, 0, 8'h09, "R10 ignore");
    run_frame(1, 2'd3, 0, 0, 1, 3'd1, 8'h2A, 3'd0, 1, 8'h77, "R3 R10 reserved action as ignore");
    run_frame(0, 2'd0, 0, 0, 1, 3'd5, 8'h3F, 3'd0, 0, 8'hC3, "R2 static publish");
    run_frame(0, 2'd1, 0, 1, 0, 3'd3, 8'h01, 3'd0, 0, 8'h5A, "R2 R7 R11 static subscribe no checksum");
    run_frame(0, 2'd2, 1, 0, 0, 3'd2, 8'hC4, 3'd0, 1, 8'hE1, "R10 R11 static ignore bad checksum");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule